// File: doc/BRIEF.md
# Program-Cycle Completion Status Reader

This block sits on the read side of a byte-wide non-volatile memory. It decides what the host sees on the data bus during a read. While no internal programming cycle is running, a read returns the array word unchanged. While a programming cycle is running, a read returns status instead, so the host can find out when the write has finished by polling. In that status word, the top bit is the inverse of the top bit of the byte just written. The next bit changes value between one read access and the next. The remaining low bits repeat the written byte. Whenever the chip select or the output enable is inactive, the block stops driving the bus.

The write controller supplies three inputs: a busy flag, which is high for the length of each programming cycle, the last byte it accepted, and the word read from the array. A write that is refused, for example under write protection, never raises the busy flag, so no status appears for it. The block samples its inputs on the system clock and registers its outputs. A host access is recognised when both active-low strobes are low at a clock edge. A new access begins at the first edge where both are low after an edge where they were not.

Top module: `writeStatusReader`

## Requirements
- R1: When `ceN` and `oeN` are both low at a rising clock edge, `dqOe` is high after that edge.
- R2: When `ceN` or `oeN` is high at a rising clock edge, after that edge `dqOe` is low and `dqOut` is all zeros (the bus is released).
- R3: During a read with `progBusy` low at the sampling edge, `dqOut` equals `arrayData` sampled at that edge, on all bits. This holds whatever `lastByte` holds, so a refused write that never raises busy produces no status.
- R4: During a read with `progBusy` high, `dqOut[7]` is the complement of `lastByte[7]`.
- R5: During a read with `progBusy` high, `dqOut[5:0]` equal `lastByte[5:0]`.
- R6: While `progBusy` is high, `dqOut[6]` takes the opposite value on each new read access compared with the previous access. It keeps one value for the whole of an access, however many cycles that access lasts.
- R7: The toggle state is cleared to 0 at the edge where `progBusy` is first seen high. The first read access of every programming cycle therefore shows `dqOut[6]` = 1, whatever the previous cycle left behind.
- R8: While `rstN` is low, `dqOe` is low and `dqOut` is zero. The toggle state resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| progBusy | input | 1 | High while an internal programming cycle runs |
| lastByte | input | 8 | Last byte accepted by the write controller |
| arrayData | input | 8 | Word read from the storage array |
| dqOut | output | 8 | Data presented to the bus |
| dqOe | output | 1 | Bus drive enable; low means high-impedance |

## Verification
Every result comes out one clock after the edge that samples its inputs. This applies to the drive enable, the pass-through word, the inverted top bit, the toggle bit and the copied low bits, because one output register sits on each path. The driver changes inputs on the falling edge. For each cycle it queues one expected item, computed from the strobes, the busy flag and a toggle model of its own. The monitor takes that item off the queue a quarter period after the next rising edge and compares it there. Accesses lasting several cycles, changes of array data in the middle of an access, and a new busy cycle that follows an odd number of reads all fall on that same one-cycle alignment.

// File: rtl/writeStatusPkg.sv
package writeStatusPkg;

  // Strobes handed from the control half to the datapath half.
  typedef struct packed {
    logic readOn;     // both strobes low this cycle
    logic readStart;  // first cycle of a new access
    logic busyRise;   // first cycle a programming cycle is seen
    logic pollMode;   // programming cycle in progress
  } pollStrb_t;

endpackage

// File: rtl/writeStatusCtrl.sv
module writeStatusCtrl
  import writeStatusPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ceN,
  input  logic      oeN,
  input  logic      progBusy,
  output pollStrb_t strb
);

  logic readOnNow;
  logic readPrev;
  logic busyPrev;

  assign readOnNow = !ceN && !oeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readPrev <= 1'b0;
      busyPrev <= 1'b0;
    end else begin
      readPrev <= readOnNow;
      busyPrev <= progBusy;
    end
  end

  always_comb begin
    strb.readOn    = readOnNow;
    strb.readStart = readOnNow && !readPrev;
    strb.busyRise  = progBusy && !busyPrev;
    strb.pollMode  = progBusy;
  end

  // R6: a start pulse never lasts two cycles in a row
  a_r6_single_start: assert property (@(posedge clk) disable iff (!rstN)
    strb.readStart |=> !strb.readStart);

endmodule

// File: rtl/writeStatusData.sv
module writeStatusData
  import writeStatusPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollStrb_t         strb,
  input  logic [DATA_W-1:0] lastByte,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe
);

  localparam logic [DATA_W-1:0] ALL_ZERO = '0;

  logic              toggleQ;
  logic              toggleBase;
  logic              toggleNext;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] wordNext;

  initial begin
    assert (POLL_BIT != TOGGLE_BIT && POLL_BIT < DATA_W && TOGGLE_BIT < DATA_W)
      else $error("status bit positions invalid");
  end

  // Toggle state: cleared at cycle start, flipped on each new access while busy.
  assign toggleBase = strb.busyRise ? 1'b0 : toggleQ;
  assign toggleNext = (strb.readStart && strb.pollMode) ? !toggleBase : toggleBase;

  // Status word assembled bit by bit.
  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_status
      if (b == POLL_BIT) begin : g_poll
        assign statusWord[b] = !lastByte[b];
      end else if (b == TOGGLE_BIT) begin : g_tog
        assign statusWord[b] = toggleNext;
      end else begin : g_copy
        assign statusWord[b] = lastByte[b];
      end
    end
  endgenerate

  always_comb begin
    if (!strb.readOn)
      wordNext = ALL_ZERO;
    else if (strb.pollMode)
      wordNext = statusWord;
    else
      wordNext = arrayData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toggleQ <= 1'b0;
      dqOut   <= ALL_ZERO;
      dqOe    <= 1'b0;
    end else begin
      toggleQ <= toggleNext;
      dqOut   <= wordNext;
      dqOe    <= strb.readOn;
    end
  end

  // R2: released bus carries zeros and no drive enable
  a_r2_release: assert property (@(posedge clk) disable iff (!rstN)
    !strb.readOn |=> !dqOe && dqOut == ALL_ZERO);

  // R3: idle reads pass the array word
  a_r3_pass: assert property (@(posedge clk) disable iff (!rstN)
    strb.readOn && !strb.pollMode |=> dqOe && dqOut == $past(arrayData));

  // R4: polling bit is inverted during programming
  a_r4_poll_inv: assert property (@(posedge clk) disable iff (!rstN)
    strb.readOn && strb.pollMode |=> dqOut[POLL_BIT] == !$past(lastByte[POLL_BIT]));

  // R6: new access while busy flips the toggle
  a_r6_flip: assert property (@(posedge clk) disable iff (!rstN)
    strb.readStart && strb.pollMode && !strb.busyRise |=> toggleQ != $past(toggleQ));

  // R6: toggle holds through the rest of an access
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    strb.readOn && !strb.readStart && !strb.busyRise |=> $stable(toggleQ));

  // R7: entering a programming cycle clears the toggle
  a_r7_init: assert property (@(posedge clk) disable iff (!rstN)
    strb.busyRise && !strb.readStart |=> toggleQ == 1'b0);

endmodule

// File: rtl/writeStatusReader.sv
module writeStatusReader
  import writeStatusPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              progBusy,
  input  logic [DATA_W-1:0] lastByte,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe
);

  pollStrb_t strb;

  writeStatusCtrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ceN      (ceN),
    .oeN      (oeN),
    .progBusy (progBusy),
    .strb     (strb)
  );

  writeStatusData #(
    .DATA_W     (DATA_W),
    .POLL_BIT   (POLL_BIT),
    .TOGGLE_BIT (TOGGLE_BIT)
  ) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .lastByte  (lastByte),
    .arrayData (arrayData),
    .dqOut     (dqOut),
    .dqOe      (dqOe)
  );

  // R1: a sampled read turns the drive on
  a_r1_drive: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN) |=> dqOe);

endmodule

// File: tb/test_writeStatusReader.sv
module test_writeStatusReader;

  typedef struct {
    logic       oe;
    logic [7:0] data;
    string      tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ceN = 1'b1;
  logic       oeN = 1'b1;
  logic       progBusy = 1'b0;
  logic [7:0] lastByte = 8'h00;
  logic [7:0] arrayData = 8'h00;
  logic [7:0] dqOut;
  logic       dqOe;

  int checks = 0;
  int errors = 0;
  expItem_t expQ[$];

  // reference model state
  logic mPrevRead = 1'b0;
  logic mPrevBusy = 1'b0;
  logic mTog = 1'b0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  writeStatusReader i_writeStatusReader (
    .clk       (clk),
    .rstN      (rstN),
    .ceN       (ceN),
    .oeN       (oeN),
    .progBusy  (progBusy),
    .lastByte  (lastByte),
    .arrayData (arrayData),
    .dqOut     (dqOut),
    .dqOe      (dqOe)
  );

  task automatic step(input logic ce, input logic oe, input logic busy,
                      input logic [7:0] last, input logic [7:0] arr, input string tag);
    expItem_t it;
    logic rd;
    @(negedge clk);
    ceN = ce; oeN = oe; progBusy = busy; lastByte = last; arrayData = arr;
    rd = !ce && !oe;
    if (busy && !mPrevBusy) mTog = 1'b0;
    if (rd && !mPrevRead && busy) mTog = !mTog;
    it.oe  = rd;
    it.tag = tag;
    if (!rd)       it.data = 8'h00;
    else if (busy) it.data = {!last[7], mTog, last[5:0]};
    else           it.data = arr;
    mPrevRead = rd;
    mPrevBusy = busy;
    expQ.push_back(it);
  endtask

  // monitor: compares a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (dqOe !== it.oe || dqOut !== it.data) begin
          errors++;
          $display("FAIL %s: actual oe=%0b data=%02h expected oe=%0b data=%02h",
                   it.tag, dqOe, dqOut, it.oe, it.data);
        end
      end
    end
  end

  // watchdog
  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R8: reset state, inputs asking for a read
    ceN = 1'b0; oeN = 1'b0; arrayData = 8'hFF;
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (dqOe !== 1'b0 || dqOut !== 8'h00) begin
      errors++;
      $display("FAIL R8: actual oe=%0b data=%02h expected oe=0 data=00", dqOe, dqOut);
    end
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
    rstN = 1'b1;

    // R1 R3: idle read, array word changes mid-access
    step(1, 1, 0, 8'h00, 8'h00, "R2");
    step(0, 0, 0, 8'h00, 8'hA5, "R1/R3");
    step(0, 0, 0, 8'h00, 8'hA5, "R3");
    step(0, 0, 0, 8'h00, 8'h3C, "R3");
    // R2: each strobe high alone releases the bus
    step(0, 1, 0, 8'h00, 8'h77, "R2");
    step(1, 0, 0, 8'h00, 8'h77, "R2");
    step(1, 1, 0, 8'h00, 8'h77, "R2");
    // R3: refused write leaves busy low; lastByte ignored
    step(0, 0, 0, 8'hFF, 8'h12, "R3");
    step(0, 0, 0, 8'h00, 8'h81, "R3");
    step(1, 1, 0, 8'hFF, 8'h12, "R2");

    // programming cycle 1, last byte 5A
    step(1, 1, 1, 8'h5A, 8'hEE, "R2");
    step(0, 0, 1, 8'h5A, 8'hEE, "R4/R5/R7");
    step(0, 0, 1, 8'h5A, 8'h11, "R6");
    step(0, 0, 1, 8'h5A, 8'h22, "R6");
    step(1, 1, 1, 8'h5A, 8'h22, "R2");
    step(0, 0, 1, 8'h5A, 8'h22, "R6");
    step(0, 0, 1, 8'h5A, 8'h22, "R6");
    step(0, 1, 1, 8'h5A, 8'h22, "R2");
    step(0, 0, 1, 8'h5A, 8'h22, "R6");
    step(1, 1, 1, 8'h5A, 8'h22, "R2");
    // cycle ends: array data again
    step(1, 1, 0, 8'h5A, 8'h9B, "R2");
    step(0, 0, 0, 8'h5A, 8'h9B, "R3");
    step(1, 1, 0, 8'h5A, 8'h9B, "R2");

    // programming cycle 2 after odd read count, last byte C3
    step(1, 1, 1, 8'hC3, 8'h00, "R2");
    step(1, 1, 1, 8'hC3, 8'h00, "R2");
    step(0, 0, 1, 8'hC3, 8'h00, "R7/R4/R5");
    step(1, 1, 1, 8'hC3, 8'h00, "R2");
    step(0, 0, 1, 8'hC3, 8'h00, "R6");
    step(1, 1, 0, 8'hC3, 8'h00, "R2");

    // busy rises on the same edge a read begins
    step(0, 0, 1, 8'h0F, 8'h55, "R7");
    step(0, 0, 1, 8'h0F, 8'h55, "R6");
    step(1, 1, 1, 8'h0F, 8'h55, "R2");
    step(0, 0, 1, 8'h80, 8'h55, "R4/R5");
    step(1, 1, 0, 8'h80, 8'h55, "R2");

    repeat (3) @(posedge clk);
    #6;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule